// File: doc/BRIEF.md
# Line Receive Poll and Upload Controller

This block sits between a powerline receiver and a host serial link. The receiver hands it decoded code bytes, each marked as an address or a function, and the block keeps up to eight of them in a small buffer. It records which of the stored bytes are functions in a bitmask. A ring output tells the host that line activity has started. Once reception has finished, the block sends a data-poll byte once per second until the host acknowledges it. It then sends the buffer as a length byte, the mask byte and the stored codes.

A second wake-up path handles power failure. After a power-fail pulse the block sends a different poll byte on every one-second tick until the host answers with a clock-update header. When both kinds of poll are waiting, the power-fail poll is sent. The one-second tick is an input. Outgoing bytes leave through a valid/ready byte interface that feeds the serial transmitter. The upload needs no acknowledge from the host: the buffer is emptied as the upload ends.

Top module: `poll_upload_ctrl`

## Requirements
- R1: `ring` is 0 after reset and becomes 1 on the clock edge that samples a `lineStart` pulse.
- R2: At most 8 code bytes are stored between uploads. Codes taken while the buffer is full are still accepted (`codeReady` stays 1) but are discarded, so the count byte never exceeds 9.
- R3: After `lineDone`, each `secTick` that finds the transmitter idle sends the data poll 0x5a. These polls stop once the host sends 0xc3.
- R4: A 0xc3 from the host while a data poll is pending starts an upload: first a count byte equal to the number of stored codes plus one, then the mask byte, then the stored codes in arrival order.
- R5: Bit i of the mask byte is 1 when stored code i was flagged as a function (`codeIsFunc`=1) and 0 when it was an address. Bit 0 belongs to the first stored code, and unused bits are 0.
- R6: The buffer is emptied when the upload ends. An upload that follows with no new codes is exactly 0x01, 0x00.
- R7: A `powerFail` pulse makes each idle `secTick` send the power-fail poll 0xa5. This continues until the host sends 0x9b.
- R8: The power-fail poll takes priority over the data poll, and `ring` returns to 0 on the edge after a 0xc3 is received.
- R9: `codeReady` is 0 from the edge after the acknowledging 0xc3 until the last upload byte has been loaded. A code held on the input during this time is taken after the upload and goes into the next one.
- R10: While `txValid`=1 and `txReady`=0, `txValid` stays 1 and `txByte` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| secTick | input | 1 | One-cycle pulse once per second |
| lineStart | input | 1 | Pulse: line reception has begun |
| codeValid | input | 1 | A received code byte is offered |
| codeByte | input | 8 | Received code byte |
| codeIsFunc | input | 1 | 1 = code is a function, 0 = an address |
| codeReady | output | 1 | Code input is being taken (low during upload) |
| lineDone | input | 1 | Pulse: line reception has ended |
| powerFail | input | 1 | Pulse: power failure detected |
| hostValid | input | 1 | A byte from the host is present |
| hostByte | input | 8 | Byte received from the host |
| txValid | output | 1 | Outgoing byte is valid |
| txByte | output | 8 | Outgoing byte |
| txReady | input | 1 | Transmitter accepts the outgoing byte |
| ring | output | 1 | Wake-up indication to the host |

## Verification
The hardest situation to reach is a code that arrives while an upload is in progress. The test sends the 0xc3 acknowledge directly, without waiting for a tick. On the next cycle it offers a code and holds it until `codeReady` comes back, then checks that this code appears only in the following upload. Power-fail polling combined with pending data is covered in the same way: several ticks are issued before 0x9b is sent, so the priority rule and the change from one poll byte to the other both show up in the byte stream. A randomly stalling `txReady` keeps the hold rule exercised throughout.

// File: rtl/poll_upload_pkg.sv
package poll_upload_pkg;
  localparam logic [7:0] DATA_POLL = 8'h5a;
  localparam logic [7:0] DATA_ACK  = 8'hc3;
  localparam logic [7:0] PF_POLL   = 8'ha5;
  localparam logic [7:0] PF_ACK    = 8'h9b;

  typedef enum logic [2:0] {
    SRC_DATA_POLL,
    SRC_PF_POLL,
    SRC_COUNT,
    SRC_MASK,
    SRC_CODE
  } txSrc_e;

  typedef struct packed {
    logic   takeCode;
    logic   loadTx;
    txSrc_e txSrc;
    logic   clearBuf;
  } dpCtl_t;
endpackage

// File: rtl/poll_upload_dp.sv
module poll_upload_dp
  import poll_upload_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CNT_W-1:0] codeIdx,
  input  logic [7:0]       codeByte,
  input  logic             codeIsFunc,
  input  logic             txReady,
  output logic [CNT_W-1:0] fillCnt,
  output logic             txValid,
  output logic [7:0]       txByte
);
  logic [7:0]       codeMem [DEPTH];
  logic [DEPTH-1:0] funcMask;
  logic [7:0]       maskByte;
  logic [7:0]       nextByte;
  logic             hasRoom;

  assign hasRoom = fillCnt < CNT_W'(DEPTH);

  // Mask byte: one bit per slot, zero above DEPTH
  for (genvar i = 0; i < 8; i++) begin : g_mask
    if (i < DEPTH) begin : g_used
      assign maskByte[i] = funcMask[i];
    end else begin : g_pad
      assign maskByte[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.takeCode && hasRoom) codeMem[fillCnt] <= codeByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt  <= '0;
      funcMask <= '0;
    end else if (ctl.clearBuf) begin
      fillCnt  <= '0;
      funcMask <= '0;
    end else if (ctl.takeCode && hasRoom) begin
      funcMask[fillCnt] <= codeIsFunc;
      fillCnt           <= fillCnt + CNT_W'(1);
    end
  end

  always_comb begin
    unique case (ctl.txSrc)
      SRC_DATA_POLL: nextByte = DATA_POLL;
      SRC_PF_POLL:   nextByte = PF_POLL;
      SRC_COUNT:     nextByte = 8'(fillCnt) + 8'd1;
      SRC_MASK:      nextByte = maskByte;
      SRC_CODE:      nextByte = codeMem[codeIdx];
      default:       nextByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= 8'h00;
    end else if (ctl.loadTx) begin
      txValid <= 1'b1;
      txByte  <= nextByte;
    end else if (txReady) begin
      txValid <= 1'b0;
    end
  end
endmodule

// File: rtl/poll_upload_ctl.sv
module poll_upload_ctl
  import poll_upload_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ITEM_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             lineStart,
  input  logic             lineDone,
  input  logic             powerFail,
  input  logic             codeValid,
  input  logic             hostValid,
  input  logic [7:0]       hostByte,
  input  logic             txValid,
  input  logic [CNT_W-1:0] fillCnt,
  output dpCtl_t           ctl,
  output logic [CNT_W-1:0] codeIdx,
  output logic             codeReady,
  output logic             ring
);
  typedef enum logic {ST_IDLE, ST_UPLOAD} state_e;

  state_e            state;
  logic [ITEM_W-1:0] itemIdx;
  logic              dataPend;
  logic              pfPend;
  logic              ackData;
  logic              ackPf;
  logic              startUpl;
  logic              lastItem;
  logic              uplStep;

  assign ackData   = hostValid && (hostByte == DATA_ACK);
  assign ackPf     = hostValid && (hostByte == PF_ACK);
  assign startUpl  = (state == ST_IDLE) && ackData && dataPend;
  assign codeReady = (state == ST_IDLE);
  assign uplStep   = (state == ST_UPLOAD) && !txValid;
  assign lastItem  = itemIdx == (ITEM_W'(fillCnt) + ITEM_W'(1));

  always_comb begin
    ctl          = '0;
    ctl.txSrc    = SRC_DATA_POLL;
    ctl.takeCode = codeValid && codeReady;
    codeIdx      = CNT_W'(itemIdx - ITEM_W'(2));
    if (uplStep) begin
      ctl.loadTx   = 1'b1;
      ctl.clearBuf = lastItem;
      if (itemIdx == '0)                ctl.txSrc = SRC_COUNT;
      else if (itemIdx == ITEM_W'(1))   ctl.txSrc = SRC_MASK;
      else                              ctl.txSrc = SRC_CODE;
    end else if ((state == ST_IDLE) && secTick && !txValid && !startUpl) begin
      if (pfPend) begin
        ctl.loadTx = 1'b1;
        ctl.txSrc  = SRC_PF_POLL;
      end else if (dataPend) begin
        ctl.loadTx = 1'b1;
        ctl.txSrc  = SRC_DATA_POLL;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      itemIdx  <= '0;
      dataPend <= 1'b0;
      pfPend   <= 1'b0;
      ring     <= 1'b0;
    end else begin
      if (lineStart)    ring <= 1'b1;
      else if (ackData) ring <= 1'b0;

      if (lineDone)      dataPend <= 1'b1;
      else if (startUpl) dataPend <= 1'b0;

      if (powerFail)  pfPend <= 1'b1;
      else if (ackPf) pfPend <= 1'b0;

      if (startUpl) begin
        state   <= ST_UPLOAD;
        itemIdx <= '0;
      end else if (uplStep) begin
        if (lastItem) state <= ST_IDLE;
        else          itemIdx <= itemIdx + ITEM_W'(1);
      end
    end
  end
endmodule

// File: rtl/poll_upload_ctrl.sv
module poll_upload_ctrl
  import poll_upload_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       lineStart,
  input  logic       codeValid,
  input  logic [7:0] codeByte,
  input  logic       codeIsFunc,
  output logic       codeReady,
  input  logic       lineDone,
  input  logic       powerFail,
  input  logic       hostValid,
  input  logic [7:0] hostByte,
  output logic       txValid,
  output logic [7:0] txByte,
  input  logic       txReady,
  output logic       ring
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  dpCtl_t           ctl;
  logic [CNT_W-1:0] codeIdx;
  logic [CNT_W-1:0] fillCnt;

  poll_upload_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .lineStart(lineStart),
    .lineDone(lineDone), .powerFail(powerFail), .codeValid(codeValid),
    .hostValid(hostValid), .hostByte(hostByte), .txValid(txValid),
    .fillCnt(fillCnt), .ctl(ctl), .codeIdx(codeIdx),
    .codeReady(codeReady), .ring(ring)
  );

  poll_upload_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .codeIdx(codeIdx),
    .codeByte(codeByte), .codeIsFunc(codeIsFunc), .txReady(txReady),
    .fillCnt(fillCnt), .txValid(txValid), .txByte(txByte)
  );
endmodule

// File: rtl/poll_upload_chk.sv
module poll_upload_chk (
  input logic       clk,
  input logic       rstN,
  input logic       lineStart,
  input logic       codeReady,
  input logic       hostValid,
  input logic [7:0] hostByte,
  input logic       txValid,
  input logic [7:0] txByte,
  input logic       txReady,
  input logic       ring
);
  p_ring_on_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> ring);

  p_ring_off_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostByte == 8'hc3 && !lineStart) |=> !ring);

  p_hold_off_after_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(codeReady) |-> $past(hostValid && hostByte == 8'hc3));

  p_tx_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte)));

  p_tx_known_r10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !$isunknown(txByte));
endmodule

bind poll_upload_ctrl poll_upload_chk u_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .codeReady(codeReady),
  .hostValid(hostValid), .hostByte(hostByte), .txValid(txValid),
  .txByte(txByte), .txReady(txReady), .ring(ring)
);

// File: tb/test_poll_upload_ctrl.sv
`timescale 1ns/1ps
module test_poll_upload_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0, lineStart = 1'b0, lineDone = 1'b0, powerFail = 1'b0;
  logic       codeValid = 1'b0, codeIsFunc = 1'b0, hostValid = 1'b0;
  logic [7:0] codeByte = 8'h00, hostByte = 8'h00;
  logic       txReady = 1'b0;
  logic       codeReady, txValid, ring;
  logic [7:0] txByte;

  int unsigned nChecks = 0, nFails = 0, cycles = 0;
  logic [7:0] gotQ[$];
  logic [7:0] expQ[$];
  logic [7:0] bufData[$];
  logic       bufFunc[$];
  logic       prevStall = 1'b0;
  logic [7:0] prevByte = 8'h00;

  always #4 clk = ~clk;

  poll_upload_ctrl i_poll_upload_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .lineStart(lineStart),
    .codeValid(codeValid), .codeByte(codeByte), .codeIsFunc(codeIsFunc),
    .codeReady(codeReady), .lineDone(lineDone), .powerFail(powerFail),
    .hostValid(hostValid), .hostByte(hostByte), .txValid(txValid),
    .txByte(txByte), .txReady(txReady), .ring(ring)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      summary();
      $finish;
    end
  end

  // transmit sink with random stalls; R10 hold check
  always @(negedge clk) begin
    logic r;
    r = ($urandom % 4) != 0;
    if (rstN && prevStall) begin
      nChecks++;
      if (!txValid || txByte != prevByte) begin
        nFails++;
        $display("FAIL R10 stall hold: actual v=%0b b=%02h expected v=1 b=%02h",
                 txValid, txByte, prevByte);
      end
    end
    prevStall = rstN && txValid && !r;
    prevByte  = txByte;
    if (rstN && txValid && r) gotQ.push_back(txByte);
    txReady <= r;
  end

  task automatic check1(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic checkSeq(string req);
    nChecks++;
    if (gotQ.size() != expQ.size()) begin
      nFails++;
      $display("FAIL %s: actual %0d bytes expected %0d bytes", req, gotQ.size(), expQ.size());
    end else begin
      foreach (expQ[i]) if (gotQ[i] !== expQ[i]) begin
        nFails++;
        $display("FAIL %s: byte %0d actual %02h expected %02h", req, i, gotQ[i], expQ[i]);
        break;
      end
    end
    gotQ.delete(); expQ.delete();
  endtask

  function automatic logic [7:0] expMask();
    logic [7:0] m = 8'h00;
    foreach (bufFunc[i]) if (i < 8) m[i] = bufFunc[i];
    return m;
  endfunction

  // expected upload from the bench's own record of stored codes
  task automatic expUpload();
    int n = (bufData.size() > 8) ? 8 : bufData.size();
    expQ.push_back(8'(n + 1));
    expQ.push_back(expMask());
    for (int i = 0; i < n; i++) expQ.push_back(bufData[i]);
    bufData.delete(); bufFunc.delete();
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 lineStart = 1'b1; @(posedge clk); #1 lineStart = 1'b0;
  endtask
  task automatic pulseDone();
    @(posedge clk); #1 lineDone = 1'b1; @(posedge clk); #1 lineDone = 1'b0;
  endtask
  task automatic pulsePf();
    @(posedge clk); #1 powerFail = 1'b1; @(posedge clk); #1 powerFail = 1'b0;
  endtask
  task automatic tick();
    @(posedge clk); #1 secTick = 1'b1; @(posedge clk); #1 secTick = 1'b0;
    idle(30);
  endtask
  task automatic hostSend(logic [7:0] b);
    @(posedge clk); #1 hostValid = 1'b1; hostByte = b;
    @(posedge clk); #1 hostValid = 1'b0;
  endtask
  task automatic sendCode(logic [7:0] b, logic f);
    @(posedge clk); #1 codeValid = 1'b1; codeByte = b; codeIsFunc = f;
    forever begin
      @(negedge clk);
      if (codeReady) break;
    end
    @(posedge clk); #1 codeValid = 1'b0;
    bufData.push_back(b); bufFunc.push_back(f);
  endtask
  task automatic sendRandom(int n);
    for (int i = 0; i < n; i++) sendCode(8'($urandom), 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    idle(5);
    @(negedge clk);
    check1("R1 reset ring", {7'd0, ring}, 8'h00);
    check1("R10 reset txValid", {7'd0, txValid}, 8'h00);
    check1("R9 reset codeReady", {7'd0, codeReady}, 8'h01);
    rstN = 1'b1;
    idle(3);

    // basic: ring, polls, upload
    pulseStart();
    @(negedge clk);
    check1("R1 ring after start", {7'd0, ring}, 8'h01);
    sendRandom(5);
    pulseDone();
    tick(); tick(); tick();
    expQ = '{8'h5a, 8'h5a, 8'h5a};
    checkSeq("R3 repeated data poll");
    hostSend(8'hc3);
    @(negedge clk);
    check1("R8 ring cleared by ack", {7'd0, ring}, 8'h00);
    idle(100);
    check1("R5 mask byte", gotQ.size() > 1 ? gotQ[1] : 8'hxx, expMask());
    expUpload();
    checkSeq("R4 upload sequence");
    tick();
    checkSeq("R3 poll stops after ack");

    // overflow
    pulseStart();
    sendRandom(11);
    pulseDone();
    tick();
    hostSend(8'hc3);
    idle(100);
    expQ.push_back(8'h5a);
    expUpload();
    checkSeq("R2 overflow drops extra codes");

    // empty after upload
    pulseDone();
    tick();
    hostSend(8'hc3);
    idle(60);
    expQ = '{8'h5a, 8'h01, 8'h00};
    checkSeq("R6 buffer cleared after upload");

    // hold-off during upload
    pulseStart();
    sendRandom(3);
    pulseDone();
    hostSend(8'hc3);
    @(negedge clk);
    check1("R9 codeReady low in upload", {7'd0, codeReady}, 8'h00);
    expUpload();
    sendCode(8'h3c, 1'b1);
    idle(80);
    pulseDone();
    hostSend(8'hc3);
    idle(80);
    expUpload();
    checkSeq("R9 held code goes to next upload");

    // power-fail priority
    pulsePf();
    pulseStart();
    sendRandom(2);
    pulseDone();
    tick(); tick();
    expQ = '{8'ha5, 8'ha5};
    checkSeq("R8 power-fail poll has priority");
    hostSend(8'h9b);
    tick();
    expQ = '{8'h5a};
    checkSeq("R7 power-fail poll stops on 9b");
    hostSend(8'hc3);
    idle(80);
    expUpload();
    checkSeq("R4 upload after power-fail");
    pulsePf();
    tick(); tick();
    hostSend(8'h9b);
    tick();
    expQ = '{8'ha5, 8'ha5};
    checkSeq("R7 power-fail poll alone");

    // random rounds
    for (int k = 0; k < 8; k++) begin
      int nt;
      pulseStart();
      sendRandom($urandom % 11);
      pulseDone();
      nt = 1 + ($urandom % 3);
      for (int t = 0; t < nt; t++) begin
        tick();
        expQ.push_back(8'h5a);
      end
      hostSend(8'hc3);
      idle(100);
      expUpload();
      checkSeq("R4 random upload round");
    end

    summary();
    $finish;
  end
endmodule